// File: doc/BRIEF.md
# Floating-Point Status and Exception Summarizer

This block holds the 32-bit status and control word of a floating-point unit. Each clock, a floating-point datapath may present a group of update requests: set or clear requests for six condition bits (overflow, underflow, divide-by-zero, inexact, fraction-rounded, fraction-inexact), a mask of invalid-operation causes, and a new 5-bit result class. The block applies them to the word in one step and then recomputes two derived summaries. The first is the invalid summary, the OR of all invalid causes. The second is the enabled-exception summary, which is set when any exception bit meets its enable.

The word mixes sticky and non-sticky bits. The any-exception bit and the inexact bit are never cleared by an update request. Overflow, underflow and divide-by-zero follow their condition. A whole-word load path lets the enables and rounding mode be written; the summaries are recomputed after a load as well. When an update carries the record flag, four summary bits are copied into a 4-bit condition field. An interrupt request is raised while the enabled summary is set and either of two exception-mode inputs is high.

Bit numbering below counts bit 0 as the most significant bit of the word, so word bit b sits at vector index 31-b.

Top module: `fpstat_unit`

## Requirements
- R1: After reset the status word, the condition field and the interrupt request are all zero.
- R2: When `ld_en` is high, the word takes `ld_word` at the clock edge; any update requests of the same cycle are applied on top of it, and the summaries are recomputed. Enables occupy word bits 24 (invalid), 25 (overflow), 26 (underflow), 27 (divide-by-zero) and 28 (inexact).
- R3: An update with an overflow (word bit 3), underflow (bit 4) or divide-by-zero (bit 5) request writes that bit to its condition; a true condition also sets the any-exception bit (bit 0), and a false one leaves bit 0 unchanged.
- R4: An inexact request (bit 6) with a true condition sets bit 6 and bit 0; with a false condition bit 6 is unchanged.
- R5: Fraction-rounded (bit 13) and fraction-inexact (bit 14) requests write their condition directly; setting bit 14 does not change bit 6.
- R6: An update ORs `inv_mask` into the invalid cause bits, `inv_mask[8:3]` to word bits 7..12 and `inv_mask[2:0]` to word bits 21..23, and a nonzero mask sets bit 0.
- R7: A result-class request replaces word bits 15..19 with `cls_val` (`cls_val[4]` at bit 15); without the request the field holds.
- R8: After every update or load, the invalid summary (bit 2) equals the OR of the nine invalid cause bits.
- R9: After every update or load, the enabled summary (bit 1) is set exactly when some exception bit (invalid summary, 3, 4, 5, 6) and its enable are both set.
- R10: An update with `record` high loads `cond_fld` with word bits 0, 1, 2, 3 of the new word (bit 0 into `cond_fld[3]`); otherwise `cond_fld` holds.
- R11: `irq` is high exactly when `mode_a` or `mode_b` is high and the enabled summary of the current word is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_en | input | 1 | Whole-word load strobe |
| ld_word | input | 32 | Word to load |
| upd | input | 1 | Update request group valid |
| ov_req | input | 1 | Overflow request |
| ov_cond | input | 1 | Overflow condition |
| un_req | input | 1 | Underflow request |
| un_cond | input | 1 | Underflow condition |
| dz_req | input | 1 | Divide-by-zero request |
| dz_cond | input | 1 | Divide-by-zero condition |
| ix_req | input | 1 | Inexact request |
| ix_cond | input | 1 | Inexact condition |
| fr_req | input | 1 | Fraction-rounded request |
| fr_cond | input | 1 | Fraction-rounded condition |
| fi_req | input | 1 | Fraction-inexact request |
| fi_cond | input | 1 | Fraction-inexact condition |
| inv_mask | input | 9 | Invalid cause bits to OR in |
| cls_req | input | 1 | Result-class request |
| cls_val | input | 5 | New result class |
| record | input | 1 | Copy summaries to condition field |
| mode_a | input | 1 | Exception mode input A |
| mode_b | input | 1 | Exception mode input B |
| status | output | 32 | Status and control word |
| cond_fld | output | 4 | Condition field |
| irq | output | 1 | Enabled-exception interrupt request |

## Verification
The assertions take for granted that request and condition inputs are only meaningful while `upd` is high. They also assume that a load may rewrite any bit, so the sticky checks are disabled in load cycles. The stimulus drives every request with `upd` high and, in every load cycle, sets only the bits it means to change. The mode inputs are held steady from one falling edge to the next, so the interrupt output sampled after a rising edge reflects a single mode setting.

// File: rtl/fpstat_unit.sv
module fpstat_unit #(
  parameter int W     = 32,
  parameter int NCAUS = 9,
  parameter int CLSW  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic [W-1:0]    ld_word,
  input  logic            upd,
  input  logic            ov_req,
  input  logic            ov_cond,
  input  logic            un_req,
  input  logic            un_cond,
  input  logic            dz_req,
  input  logic            dz_cond,
  input  logic            ix_req,
  input  logic            ix_cond,
  input  logic            fr_req,
  input  logic            fr_cond,
  input  logic            fi_req,
  input  logic            fi_cond,
  input  logic [NCAUS-1:0] inv_mask,
  input  logic            cls_req,
  input  logic [CLSW-1:0] cls_val,
  input  logic            record,
  input  logic            mode_a,
  input  logic            mode_b,
  output logic [W-1:0]    status,
  output logic [3:0]      cond_fld,
  output logic            irq
);
  localparam int ANY = W-1;
  localparam int ENS = W-2;
  localparam int VXS = W-3;
  localparam int OVB = W-4;
  localparam int UNB = W-5;
  localparam int DZB = W-6;
  localparam int IXB = W-7;
  localparam int CAH = W-8;
  localparam int CAL = W-13;
  localparam int FRB = W-14;
  localparam int FIB = W-15;
  localparam int CLH = W-16;
  localparam int CLL = CLH-CLSW+1;
  localparam int CBH = W-22;
  localparam int CBL = W-24;
  localparam int EVX = W-25;
  localparam int EOV = W-26;
  localparam int EUN = W-27;
  localparam int EDZ = W-28;
  localparam int EIX = W-29;

  logic [W-1:0] base, stg, nxt;
  logic         inv_or, ens_n;

  assign base = ld_en ? ld_word : status;

  always_comb begin
    stg = base;
    if (upd) begin
      if (ov_req) begin
        stg[OVB] = ov_cond;
        if (ov_cond) stg[ANY] = 1'b1;
      end
      if (un_req) begin
        stg[UNB] = un_cond;
        if (un_cond) stg[ANY] = 1'b1;
      end
      if (dz_req) begin
        stg[DZB] = dz_cond;
        if (dz_cond) stg[ANY] = 1'b1;
      end
      if (ix_req && ix_cond) begin
        stg[IXB] = 1'b1;
        stg[ANY] = 1'b1;
      end
      if (fr_req) stg[FRB] = fr_cond;
      if (fi_req) stg[FIB] = fi_cond;
      if (|inv_mask) begin
        stg[CAH:CAL] = stg[CAH:CAL] | inv_mask[NCAUS-1:3];
        stg[CBH:CBL] = stg[CBH:CBL] | inv_mask[2:0];
        stg[ANY]     = 1'b1;
      end
      if (cls_req) stg[CLH:CLL] = cls_val;
    end
  end

  assign inv_or = (|stg[CAH:CAL]) | (|stg[CBH:CBL]);
  assign ens_n  = (inv_or & stg[EVX]) | (stg[OVB] & stg[EOV]) | (stg[UNB] & stg[EUN])
                | (stg[DZB] & stg[EDZ]) | (stg[IXB] & stg[EIX]);

  always_comb begin
    nxt      = stg;
    nxt[VXS] = inv_or;
    nxt[ENS] = ens_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status   <= '0;
      cond_fld <= '0;
    end else begin
      if (ld_en || upd) status <= nxt;
      if (upd && record) cond_fld <= {nxt[ANY], nxt[ENS], nxt[VXS], nxt[OVB]};
    end
  end

  assign irq = (mode_a | mode_b) & status[ENS];

  a_r3_any_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && status[ANY]) |=> status[ANY]);

  a_r4_inexact_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && upd && ix_req && !ix_cond) |=> status[IXB] == $past(status[IXB]));

  a_r6_invalid_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && |inv_mask) |=> (status[ANY] && status[VXS]));

  a_r7_class_write: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && cls_req) |=> status[CLH:CLL] == $past(cls_val));

  a_r8_vxs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (upd || ld_en) |=> status[VXS] == ((|status[CAH:CAL]) || (|status[CBH:CBL])));

  a_r10_cond_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd && record) |=> $stable(cond_fld));

  a_r10_cond_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && record) |=> cond_fld == {status[ANY], status[ENS], status[VXS], status[OVB]});

  a_r11_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_a && !mode_b) |-> !irq);
endmodule

// File: tb/fpstat_unit_tb.sv
module fpstat_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_en, upd, ov_req, ov_cond, un_req, un_cond, dz_req, dz_cond;
  logic ix_req, ix_cond, fr_req, fr_cond, fi_req, fi_cond, cls_req, record, mode_a, mode_b;
  logic [31:0] ld_word;
  logic [8:0]  inv_mask;
  logic [4:0]  cls_val;
  logic [31:0] status;
  logic [3:0]  cond_fld;
  logic        irq;

  int checks = 0, errors = 0;

  typedef struct { logic [31:0] st; logic [3:0] cf; logic iq; string tag; } exp_t;
  exp_t sbq[$];

  logic [31:0] m_st = '0;
  logic [3:0]  m_cf = '0;

  always #5 clk = ~clk;

  fpstat_unit u_dut (.*);

  function automatic int p(int b); return 31 - b; endfunction

  task automatic chk(string tag, logic [31:0] a, logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic idle_inputs();
    ld_en = 0; ld_word = '0; upd = 0; ov_req = 0; ov_cond = 0; un_req = 0; un_cond = 0;
    dz_req = 0; dz_cond = 0; ix_req = 0; ix_cond = 0; fr_req = 0; fr_cond = 0;
    fi_req = 0; fi_cond = 0; inv_mask = '0; cls_req = 0; cls_val = '0; record = 0;
  endtask

  task automatic step(string tag);
    exp_t e;
    logic [31:0] n;
    logic vx;
    n = ld_en ? ld_word : m_st;
    if (upd) begin
      if (ov_req) begin n[p(3)] = ov_cond; if (ov_cond) n[p(0)] = 1; end
      if (un_req) begin n[p(4)] = un_cond; if (un_cond) n[p(0)] = 1; end
      if (dz_req) begin n[p(5)] = dz_cond; if (dz_cond) n[p(0)] = 1; end
      if (ix_req && ix_cond) begin n[p(6)] = 1; n[p(0)] = 1; end
      if (fr_req) n[p(13)] = fr_cond;
      if (fi_req) n[p(14)] = fi_cond;
      for (int i = 0; i < 6; i++) if (inv_mask[8-i]) n[p(7+i)] = 1;
      for (int i = 0; i < 3; i++) if (inv_mask[2-i]) n[p(21+i)] = 1;
      if (inv_mask != 0) n[p(0)] = 1;
      if (cls_req) for (int i = 0; i < 5; i++) n[p(15+i)] = cls_val[4-i];
    end
    if (ld_en || upd) begin
      vx = 0;
      for (int i = 7; i <= 12; i++) vx |= n[p(i)];
      for (int i = 21; i <= 23; i++) vx |= n[p(i)];
      n[p(2)] = vx;
      n[p(1)] = (vx & n[p(24)]) | (n[p(3)] & n[p(25)]) | (n[p(4)] & n[p(26)])
              | (n[p(5)] & n[p(27)]) | (n[p(6)] & n[p(28)]);
      m_st = n;
    end
    if (upd && record) m_cf = {m_st[p(0)], m_st[p(1)], m_st[p(2)], m_st[p(3)]};
    e.st = m_st; e.cf = m_cf; e.iq = (mode_a | mode_b) & m_st[p(1)]; e.tag = tag;
    sbq.push_back(e);
    @(posedge clk);
  endtask

  always @(posedge clk) begin
    #3;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk({e.tag, " status"}, status, e.st);
      chk({e.tag, " cond"}, {28'd0, cond_fld}, {28'd0, e.cf});
      chk({e.tag, " irq"}, {31'd0, irq}, {31'd0, e.iq});
    end
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs(); mode_a = 0; mode_b = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 status", status, 32'd0);
    chk("R1 cond", {28'd0, cond_fld}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rst_n = 1;

    @(negedge clk); idle_inputs();
    ld_en = 1; ld_word[p(24)] = 1; ld_word[p(25)] = 1; ld_word[p(31)] = 1;
    step("R2 load enables");

    @(negedge clk); idle_inputs(); upd = 1; ov_req = 1; ov_cond = 1; record = 1;
    step("R3 R9 R10 overflow set");

    @(negedge clk); idle_inputs(); mode_b = 1;
    step("R11 irq mode_b");

    @(negedge clk); idle_inputs(); mode_b = 0; mode_a = 1; upd = 1; ov_req = 1; ov_cond = 0;
    step("R3 R9 overflow clear keeps any");

    @(negedge clk); idle_inputs(); upd = 1; dz_req = 1; dz_cond = 1; un_req = 1; un_cond = 1;
    step("R3 zdiv underflow set");

    @(negedge clk); idle_inputs(); upd = 1; ix_req = 1; ix_cond = 1;
    step("R4 inexact set");

    @(negedge clk); idle_inputs(); upd = 1; ix_req = 1; ix_cond = 0;
    step("R4 inexact false holds");

    @(negedge clk); idle_inputs(); ld_en = 1; ld_word[p(28)] = 1;
    step("R2 R9 load inexact enable only");

    @(negedge clk); idle_inputs(); upd = 1; fi_req = 1; fi_cond = 1; fr_req = 1; fr_cond = 1;
    step("R5 fraction bits set");

    @(negedge clk); idle_inputs(); upd = 1; fr_req = 1; fr_cond = 0;
    step("R5 fraction rounded clear");

    @(negedge clk); idle_inputs(); ld_en = 1; ld_word[p(24)] = 1;
    step("R2 load invalid enable");

    @(negedge clk); idle_inputs(); upd = 1; inv_mask = 9'b100000001; record = 1;
    step("R6 R8 R9 R10 invalid mask");

    @(negedge clk); idle_inputs(); upd = 1; inv_mask = 9'b010000100;
    step("R6 invalid accumulate");

    @(negedge clk); idle_inputs(); ld_en = 1; ld_word[p(24)] = 1; ld_word[p(0)] = 1;
    step("R8 R9 load clears causes");

    @(negedge clk); idle_inputs(); upd = 1; cls_req = 1; cls_val = 5'b10110;
    step("R7 class write");

    @(negedge clk); idle_inputs(); upd = 1; cls_val = 5'b01001; ov_req = 1; ov_cond = 1;
    step("R7 class hold R10 no record");

    @(negedge clk); idle_inputs(); upd = 1; cls_req = 1; cls_val = 5'b01001; record = 1;
    step("R7 R10 class replace record");

    @(negedge clk); idle_inputs(); mode_a = 0; mode_b = 0;
    step("R11 irq modes off");

    @(negedge clk); idle_inputs();
    step("R1 idle tail");
    @(posedge clk); #4;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule